// File: doc/BRIEF.md
# Bus-to-Asynchronous Flash Bridge

This block is a synchronous bus slave that uses the classic single-cycle handshake. It converts each read or write bus cycle into the slow asynchronous strobes that a parallel NOR-style flash needs. A transfer begins when cycle and strobe are both high at a rising clock edge. The bridge then latches the address and byte selects and drives them to the memory side. It holds chip select and either output enable or write enable low for a fixed number of clock periods, then acknowledges. The read and write periods are set by separate elaboration-time parameters.

On a read, the bridge captures the flash data on the edge that raises acknowledge and keeps it on the bus read-data output until the next read completes. On a write, the memory data bus follows the bus write data. Write enable is released on the same edge that raises acknowledge, and chip select stays low through that acknowledge cycle. The memory therefore latches on the write-enable rising edge, never on a chip-select edge. Three side pins (byte mode, write protect, flash reset) carry constant levels chosen by parameters. Bursts are serviced as consecutive single transfers. If the master drops its request before the latency runs out, the transfer is abandoned without an acknowledge.

Top module: `flash_bridge`

## Requirements
- R1: While rst_ni is low, and after it is released, ack_o is 0, dat_o is 0, mem_adr_o is 0, mem_ce_no, mem_oe_no and mem_we_no are 1, mem_lane_no is all ones, and the bridge does not drive mem_dq_io.
- R2: When cyc_i and stb_i are both 1 at a rising edge with the bridge idle, mem_adr_o takes adr_i and mem_ce_no goes low after that edge.
- R3: For a read, mem_oe_no is low for exactly RD_LAT clock periods after the start edge. ack_o rises on the edge at which mem_oe_no returns high.
- R4: On the edge at which a read acknowledge rises, dat_o takes the value on mem_dq_io. Writes and aborted transfers leave dat_o unchanged.
- R5: For a write, mem_we_no is low for exactly WR_LAT clock periods after the start edge, and ack_o rises on the same edge at which mem_we_no returns high.
- R6: mem_dq_io carries dat_i from the start of a write through its acknowledge cycle. At all other times it is high-impedance.
- R7: ack_o is high for exactly one clock period per completed transfer, and it then returns to idle.
- R8: If cyc_i or stb_i is 0 at any edge before or at the terminal edge of the latency count, the bridge goes idle and releases all strobes without raising ack_o. Abort takes priority over the terminal count.
- R9: mem_ce_no is low whenever mem_oe_no or mem_we_no is low, and it stays low during the acknowledge cycle.
- R10: mem_lane_no is active low. During a transfer, bit n equals the inverse of the byte select latched at the start, and it covers data bits 8n+7 to 8n. While idle it is all ones.
- R11: mem_byte_o, mem_wp_no and mem_rst_no are constant at the levels of parameters BYTE_LVL, WP_LVL and RST_LVL, each 1 by default.
- R12: mem_oe_no and mem_we_no are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adr_i | input | AW | Bus address |
| dat_i | input | DW | Bus write data |
| dat_o | output | DW | Bus read data |
| sel_i | input | DW/8 | Byte selects |
| we_i | input | 1 | Write cycle when high |
| stb_i | input | 1 | Strobe |
| cyc_i | input | 1 | Cycle valid |
| ack_o | output | 1 | Acknowledge, one-cycle pulse |
| mem_adr_o | output | AW | Flash address |
| mem_dq_io | inout | DW | Flash data bus |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_lane_no | output | DW/8 | Byte-lane enables, active low |
| mem_byte_o | output | 1 | Static byte/word mode level |
| mem_wp_no | output | 1 | Static write-protect level |
| mem_rst_no | output | 1 | Static flash reset level |

## Verification
Two events can fall on the same edge. The terminal edge of the latency count can coincide with the master withdrawing its request, and the write-enable release always coincides with the acknowledge rise. To provoke the first, the bench drops strobe and cycle in the clock period just before the terminal edge. It then expects no acknowledge, released strobes and an unchanged dat_o. The second is judged at the acknowledge cycle itself: write enable must already be high, chip select still low, and the data bus still carrying dat_i. Random transfers with random gaps and early aborts repeat both situations at many addresses and byte masks.

// File: rtl/flash_bridge_pkg.sv
package flash_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } fb_state_e;
endpackage

// File: rtl/flash_bridge_lat_cnt.sv
module flash_bridge_lat_cnt #(
  parameter int LAT = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + CW'(1);
  end

  // terminal when LAT-1 periods have already elapsed
  assign hit_o = (cnt_q == CW'(LAT - 1));
endmodule

// File: rtl/flash_bridge_seq.sv
module flash_bridge_seq
  import flash_bridge_pkg::*;
#(
  parameter int RD_LAT = 7,
  parameter int WR_LAT = 7
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cyc_i,
  input  logic      stb_i,
  input  logic      we_i,
  output fb_state_e state_o,
  output logic      wr_q_o,
  output logic      start_o,
  output logic      cap_o,
  output logic      ack_o
);
  fb_state_e state_q;
  logic      wr_q;
  logic      ack_q;
  logic      req;
  logic      term;
  logic [1:0] hit;

  assign req     = cyc_i & stb_i;
  assign start_o = (state_q == ST_IDLE) & req;

  // index 0: read counter, index 1: write counter
  for (genvar g = 0; g < 2; g++) begin : g_lat
    localparam int LAT_G = (g == 0) ? RD_LAT : WR_LAT;
    flash_bridge_lat_cnt #(.LAT(LAT_G)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_o),
      .en_i   ((state_q == ST_BUSY) && (wr_q == (g == 1))),
      .hit_o  (hit[g])
    );
  end

  assign term  = wr_q ? hit[1] : hit[0];
  assign cap_o = (state_q == ST_BUSY) & req & term & ~wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req) begin
          state_q <= ST_BUSY;
          wr_q    <= we_i;
        end
        ST_BUSY: begin
          if (!req) state_q <= ST_IDLE;          // abort wins over terminal count
          else if (term) begin
            state_q <= ST_DONE;
            ack_q   <= 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign wr_q_o  = wr_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/flash_bridge_dp.sv
module flash_bridge_dp
  import flash_bridge_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fb_state_e     state_i,
  input  logic          wr_i,
  input  logic          start_i,
  input  logic          cap_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  input  logic [BW-1:0] sel_i,
  output logic [DW-1:0] dat_o,
  output logic [AW-1:0] mem_adr_o,
  inout  wire  [DW-1:0] mem_dq_io,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [BW-1:0] mem_lane_no
);
  logic [AW-1:0] adr_q;
  logic [BW-1:0] sel_q;
  logic [DW-1:0] rd_q;
  logic          active;
  logic          busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q <= '0;
      sel_q <= '0;
    end else if (start_i) begin
      adr_q <= adr_i;
      sel_q <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (cap_i) rd_q <= mem_dq_io;
  end

  assign active = (state_i != ST_IDLE);
  assign busy   = (state_i == ST_BUSY);

  assign mem_ce_no   = ~active;
  assign mem_oe_no   = ~(busy & ~wr_i);
  assign mem_we_no   = ~(busy & wr_i);
  assign mem_lane_no = active ? ~sel_q : '1;
  // data held through the ack cycle for hold time after the we rising edge
  assign mem_dq_io   = (active & wr_i) ? dat_i : 'z;
  assign mem_adr_o   = adr_q;
  assign dat_o       = rd_q;
endmodule

// File: rtl/flash_bridge.sv
module flash_bridge
  import flash_bridge_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 32,
  parameter int RD_LAT   = 7,
  parameter int WR_LAT   = 7,
  parameter bit BYTE_LVL = 1'b1,
  parameter bit WP_LVL   = 1'b1,
  parameter bit RST_LVL  = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   adr_i,
  input  logic [DW-1:0]   dat_i,
  output logic [DW-1:0]   dat_o,
  input  logic [DW/8-1:0] sel_i,
  input  logic            we_i,
  input  logic            stb_i,
  input  logic            cyc_i,
  output logic            ack_o,
  output logic [AW-1:0]   mem_adr_o,
  inout  wire  [DW-1:0]   mem_dq_io,
  output logic            mem_ce_no,
  output logic            mem_oe_no,
  output logic            mem_we_no,
  output logic [DW/8-1:0] mem_lane_no,
  output logic            mem_byte_o,
  output logic            mem_wp_no,
  output logic            mem_rst_no
);
  localparam int BW = DW / 8;

  fb_state_e state;
  logic      wr_q;
  logic      start;
  logic      cap;

  flash_bridge_seq #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cyc_i   (cyc_i),
    .stb_i   (stb_i),
    .we_i    (we_i),
    .state_o (state),
    .wr_q_o  (wr_q),
    .start_o (start),
    .cap_o   (cap),
    .ack_o   (ack_o)
  );

  flash_bridge_dp #(.AW(AW), .DW(DW), .BW(BW)) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .wr_i        (wr_q),
    .start_i     (start),
    .cap_i       (cap),
    .adr_i       (adr_i),
    .dat_i       (dat_i),
    .sel_i       (sel_i),
    .dat_o       (dat_o),
    .mem_adr_o   (mem_adr_o),
    .mem_dq_io   (mem_dq_io),
    .mem_ce_no   (mem_ce_no),
    .mem_oe_no   (mem_oe_no),
    .mem_we_no   (mem_we_no),
    .mem_lane_no (mem_lane_no)
  );

  assign mem_byte_o = BYTE_LVL;
  assign mem_wp_no  = WP_LVL;
  assign mem_rst_no = RST_LVL;
endmodule

// File: rtl/flash_bridge_chk.sv
module flash_bridge_chk #(
  parameter int RD_LAT = 7,
  parameter int WR_LAT = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_i,
  input logic stb_i,
  input logic ack_o,
  input logic mem_ce_no,
  input logic mem_oe_no,
  input logic mem_we_no
);
  logic [4:0] rd_run;
  logic [4:0] wr_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= mem_oe_no ? 5'd0 : ((rd_run == 5'd31) ? rd_run : rd_run + 5'd1);
      wr_run <= mem_we_no ? 5'd0 : ((wr_run == 5'd31) ? wr_run : wr_run + 5'd1);
    end
  end

  p_rd_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_oe_no) && ack_o) |-> (rd_run == 5'(RD_LAT)));

  p_wr_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_we_no) && ack_o) |-> (wr_run == 5'(WR_LAT)));

  p_strobe_off_at_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (mem_we_no && mem_oe_no));

  p_ack_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_ack_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(cyc_i && stb_i));

  p_cs_at_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !mem_ce_no);

  p_strobe_needs_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_ce_no);

  p_no_overlap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
endmodule

bind flash_bridge flash_bridge_chk #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cyc_i     (cyc_i),
  .stb_i     (stb_i),
  .ack_o     (ack_o),
  .mem_ce_no (mem_ce_no),
  .mem_oe_no (mem_oe_no),
  .mem_we_no (mem_we_no)
);

// File: tb/test_flash_bridge.sv
`timescale 1ns/1ps
module test_flash_bridge;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int RD = 3;
  localparam int WR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] dat_w = '0;
  logic [DW-1:0] dat_r;
  logic [BW-1:0] sel = '0;
  logic          we = 1'b0, stb = 1'b0, cyc = 1'b0;
  logic          ack;
  logic [AW-1:0] m_adr;
  wire  [DW-1:0] dq;
  logic          ce_n, oe_n, we_n;
  logic [BW-1:0] lane_n;
  logic          byte_o, wp_n, rst_on;

  logic [DW-1:0] fl_val = '0;
  logic          probe_en = 1'b0;
  logic [DW-1:0] probe_val = '0;
  logic [DW-1:0] last_rd = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // flash model drives only while selected and output-enabled
  assign dq = (!ce_n && !oe_n) ? fl_val : 'z;
  assign dq = probe_en ? probe_val : 'z;

  flash_bridge #(.AW(AW), .DW(DW), .RD_LAT(RD), .WR_LAT(WR)) i_flash_bridge (
    .clk_i(clk), .rst_ni(rst_n), .adr_i(adr), .dat_i(dat_w), .dat_o(dat_r),
    .sel_i(sel), .we_i(we), .stb_i(stb), .cyc_i(cyc), .ack_o(ack),
    .mem_adr_o(m_adr), .mem_dq_io(dq), .mem_ce_no(ce_n), .mem_oe_no(oe_n),
    .mem_we_no(we_n), .mem_lane_no(lane_n), .mem_byte_o(byte_o),
    .mem_wp_no(wp_n), .mem_rst_no(rst_on)
  );

  function automatic logic [BW-1:0] exp_lanes(input logic [BW-1:0] s);
    return ~s;
  endfunction

  function automatic int exp_lat(input bit wr);
    return wr ? WR : RD;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_float_check(input string tag);
    probe_val = $urandom;
    probe_en  = 1'b1;
    #1;
    chk(tag, 64'(dq), 64'(probe_val));
    probe_en  = 1'b0;
  endtask

  // abort_at: 0 = complete, else drop request after n-th period
  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] s,
                      input logic [DW-1:0] d, input int abort_at);
    int lat = exp_lat(wr);
    adr = a; sel = s; we = wr; dat_w = d; fl_val = d; cyc = 1'b1; stb = 1'b1;
    if (abort_at > 0) begin
      for (int n = 1; n <= abort_at; n++) begin
        @(negedge clk);
        chk("R2 ce during transfer", 64'(ce_n), 64'd0);
      end
      cyc = 1'b0; stb = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R8 no ack after abort", 64'(ack), 64'd0);
        chk("R8 strobes released", 64'({ce_n, oe_n, we_n}), 64'b111);
      end
      chk("R4 dat_o kept on abort", 64'(dat_r), 64'(last_rd));
      return;
    end
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      chk("R7 no early ack", 64'(ack), 64'd0);
      if (wr) chk("R5 we low", 64'({we_n, oe_n}), 64'b01);
      else    chk("R3 oe low", 64'({oe_n, we_n}), 64'b01);
      if (n == 1) begin
        chk("R2 address", 64'(m_adr), 64'(a));
        chk("R2 ce low", 64'(ce_n), 64'd0);
        chk("R10 lanes", 64'(lane_n), 64'(exp_lanes(s)));
      end
      if (wr) chk("R6 dq carries write data", 64'(dq), 64'(d));
    end
    @(negedge clk);
    chk("R7 ack rises", 64'(ack), 64'd1);
    chk(wr ? "R5 we released at ack" : "R3 oe released at ack", 64'({oe_n, we_n}), 64'b11);
    chk("R9 ce held at ack", 64'(ce_n), 64'd0);
    if (wr) begin
      chk("R6 dq held in ack cycle", 64'(dq), 64'(d));
      chk("R4 dat_o kept on write", 64'(dat_r), 64'(last_rd));
    end else begin
      last_rd = d;
      chk("R4 read data", 64'(dat_r), 64'(d));
    end
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);
    chk("R7 ack single pulse", 64'(ack), 64'd0);
    chk("R10 lanes idle", 64'(lane_n), 64'(exp_lanes('0)));
    chk("R1 ce idle", 64'(ce_n), 64'd1);
    if (wr) idle_float_check("R6 dq released after write");
  endtask

  initial begin
    void'($urandom(32'h1F1A5));
    repeat (3) @(negedge clk);
    chk("R1 ack reset", 64'(ack), 64'd0);
    chk("R1 dat_o reset", 64'(dat_r), 64'd0);
    chk("R1 adr reset", 64'(m_adr), 64'd0);
    chk("R1 strobes reset", 64'({ce_n, oe_n, we_n}), 64'b111);
    chk("R1 lanes reset", 64'(lane_n), 64'(exp_lanes('0)));
    idle_float_check("R1 dq undriven");
    chk("R11 static pins", 64'({byte_o, wp_n, rst_on}), 64'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 64'({ack, ce_n}), 64'b01);

    xfer(1'b0, 16'h1234, 4'b1111, 32'hA5A5_0F0F, 0);
    xfer(1'b1, 16'hBEEF, 4'b0101, 32'hDEAD_BEEF, 0);
    xfer(1'b0, 16'h0001, 4'b0001, 32'h0000_00C3, 1);      // early abort
    xfer(1'b0, 16'h0002, 4'b0011, 32'h7777_1111, RD);     // abort on terminal edge, R8
    xfer(1'b1, 16'h0003, 4'b1000, 32'h1357_9BDF, WR);     // write abort on terminal edge, R8
    xfer(1'b1, 16'hFFFF, 4'b1111, 32'hFFFF_FFFF, 0);
    xfer(1'b0, 16'h0000, 4'b1111, 32'h0000_0000, 0);

    for (int i = 0; i < 300; i++) begin
      bit            wr  = 1'($urandom);
      int            ab  = 0;
      logic [BW-1:0] s   = BW'($urandom);
      if (s == '0) s = 4'b0001;
      if (($urandom % 6) == 0) ab = 1 + int'($urandom % exp_lat(wr));
      xfer(wr, AW'($urandom), s, $urandom, ab);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk("R12 idle strobes", 64'({oe_n, we_n}), 64'b11);
      end
      chk("R11 static pins hold", 64'({byte_o, wp_n, rst_on}), 64'b111);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule